// File: doc/BRIEF.md
# Consumer Data-Hold Watchdog

This block supervises up to eight cyclic consumer connections. Each consumer has a hold counter that counts down once per send cycle. A valid frame for that consumer reloads the counter. The send cycle is a power-of-two multiple of an external base tick. The base tick is nominally 31.25 us, and the multiple is given as a shift amount.

When a consumer's counter runs out, the block does three things:
- It marks the consumer as failed.
- It posts an expiry event code into a single-entry mailbox.
- It stops every provider in the consumer's application-relation group. To do this it ANDs that group's inverted membership mask into the provider-active field.

The host configures the block through simple write strobes:
- It activates or deactivates a consumer, with a reload value and a group number.
- It programs the group masks.
- It writes the provider-active field.
- It clears the mailbox.

Frame parsing is outside the block. A one-cycle strobe with a consumer index reports each valid frame.

Top module: `cons_hold_watchdog`

## Requirements
- R1: After synchronous reset all of these are zero: consumer run bits, expired bits, provider-active bits, the mailbox pending flag and the event code. All group masks reset to 8'hFF, meaning no members.
- R2: An activation write (act_we=1, act_on=1) does all of the following on the next clock edge:
  - sets the consumer's run bit to 1;
  - clears its expired bit;
  - loads its counter from the 8-bit act_reload (1..255);
  - stores its 3-bit group number.
- R3: A send cycle completes on every 2^scf_shift-th base_tick pulse. The shift is clamped to 12.
- R4: A running consumer that receives no frame fails on the edge of the act_reload-th send-cycle completion after activation. At that edge its run bit becomes 0 and its expired bit becomes 1.
- R5: A valid frame for a running consumer reloads its counter. This holds even when the frame arrives in the same cycle as a send-cycle completion, so that completion does not cause expiry.
- R6: A consumer that is not active is ignored: frames and send cycles have no effect on it, and it never expires or posts an event.
- R7: On expiry of a consumer in group g, each provider-active bit i is cleared when bit i of mask g is 0. Bits whose mask bit is 1 keep their value.
- R8: Any expiry sets the mailbox pending flag and writes event code 8'h01. mbox_clr clears the pending flag. An expiry in the same cycle as a clear wins.
- R9: A failed consumer stays failed, ignoring frames and send cycles, until the host activates it again.
- R10: A provider-active bit is set only by a host write (prov_we). An expiry never sets a provider-active bit.
- R11: A deactivation write (act_on=0) drops the consumer's run bit to 0 without setting its expired bit or posting an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | Base time tick strobe |
| scf_shift | input | 4 | Send clock factor as a shift amount |
| frame_valid | input | 1 | Valid frame strobe |
| frame_idx | input | 3 | Consumer index of the valid frame |
| act_we | input | 1 | Consumer activation write strobe |
| act_idx | input | 3 | Consumer being written |
| act_on | input | 1 | 1 activates, 0 deactivates |
| act_reload | input | 8 | Hold reload value in send cycles |
| act_group | input | 3 | Group number of the consumer |
| mask_we | input | 1 | Group mask write strobe |
| mask_grp | input | 3 | Group being written |
| mask_data | input | 8 | Inverted membership mask (0 = member) |
| prov_we | input | 1 | Provider-active write strobe |
| prov_data | input | 8 | New provider-active field |
| mbox_clr | input | 1 | Clears the pending flag |
| cons_run | output | 8 | Per-consumer run (1) / failure or idle (0) |
| cons_expired | output | 8 | Per-consumer expired indication |
| prov_active | output | 8 | Provider-active field |
| evt_pending | output | 1 | Mailbox holds an unread event |
| evt_code | output | 8 | Last posted event code |

## Verification
These faults show at the ports on the edge where the send cycle completes:
- A prescaler that counts wrong moves the failing edge of a consumer by whole send cycles.
- A counter with an off-by-one reload does the same.

These faults show one edge after an expiry, through the provider-active field and the mailbox:
- A corrupted group number, or a wrong mask register, clears the wrong provider bits.
- A lost priority between a frame and a send-cycle completion produces a spurious expiry.

Stale state in a failed or idle consumer would show up as an event that should never appear.

// File: rtl/cons_hold_pkg.sv
package cons_hold_pkg;
    localparam int N_CONS    = 8;
    localparam int N_PROV    = 8;
    localparam int N_GRP     = 8;
    localparam int IDX_W     = $clog2(N_CONS);
    localparam int GRP_W     = $clog2(N_GRP);
    localparam int CNT_W     = 8;
    localparam int MAX_SHIFT = 12;
    localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);

    typedef enum logic [7:0] {
        EV_NONE      = 8'h00,
        EV_HOLD_EXP  = 8'h01,
        EV_BAD_CRC   = 8'h02,
        EV_BAD_SEQ   = 8'h03,
        EV_BAD_STAT  = 8'h04,
        EV_CLIST_CHG = 8'h05,
        EV_PLIST_CHG = 8'h06,
        EV_BOTH_CHG  = 8'h0B
    } evt_code_e;

    typedef struct packed {
        logic             active;
        logic             run;
        logic             expired;
        logic [CNT_W-1:0] cnt;
        logic [GRP_W-1:0] grp;
    } chan_state_t;

    function automatic logic [MAX_SHIFT-1:0] cycle_limit(input logic [SHIFT_W-1:0] sh);
        logic [SHIFT_W-1:0] s;
        s = (sh > SHIFT_W'(MAX_SHIFT)) ? SHIFT_W'(MAX_SHIFT) : sh;
        return MAX_SHIFT'((1 << s) - 1);
    endfunction
endpackage

// File: rtl/cons_hold_prescaler.sv
module cons_hold_prescaler
    import cons_hold_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               base_tick_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic               cycle_o
);
    logic [MAX_SHIFT-1:0] pre_q;
    logic [MAX_SHIFT-1:0] limit;

    assign limit   = cycle_limit(shift_i);
    assign cycle_o = base_tick_i && (pre_q >= limit);

    always_ff @(posedge clk) begin
        if (rst)
            pre_q <= '0;
        else if (base_tick_i)
            pre_q <= cycle_o ? '0 : pre_q + 1'b1;
    end

    // R3
    cycle_restart_chk: assert property (@(posedge clk) disable iff (rst)
        cycle_o |=> pre_q == '0);
endmodule

// File: rtl/cons_hold_channel.sv
module cons_hold_channel
    import cons_hold_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cycle_i,
    input  logic             frame_i,
    input  logic             act_we_i,
    input  logic             act_on_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [GRP_W-1:0] group_i,
    output logic             run_o,
    output logic             expired_o,
    output logic             expire_o,
    output logic [GRP_W-1:0] group_o
);
    chan_state_t st_q;
    chan_state_t st_d;
    logic [CNT_W-1:0] reload_q;

    assign run_o     = st_q.run;
    assign expired_o = st_q.expired;
    assign group_o   = st_q.grp;
    assign expire_o  = st_q.active && st_q.run && cycle_i && !frame_i &&
                       !act_we_i && (st_q.cnt <= CNT_W'(1));

    always_comb begin
        st_d = st_q;
        if (act_we_i) begin
            st_d.active  = act_on_i;
            st_d.run     = act_on_i;
            st_d.expired = 1'b0;
            if (act_on_i) begin
                st_d.cnt = reload_i;
                st_d.grp = group_i;
            end
        end else if (st_q.active && st_q.run) begin
            if (frame_i)
                st_d.cnt = reload_q;
            else if (expire_o) begin
                st_d.cnt     = '0;
                st_d.run     = 1'b0;
                st_d.expired = 1'b1;
            end else if (cycle_i)
                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            reload_q <= CNT_W'(3);
        end else begin
            st_q <= st_d;
            if (act_we_i && act_on_i)
                reload_q <= reload_i;
        end
    end

    // R4
    expire_state_chk: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> (!run_o && expired_o));
    // R5
    frame_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (cycle_i && frame_i && run_o && !act_we_i) |=> run_o);
    // R9
    failed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (expired_o && !act_we_i) |=> (expired_o && !run_o));
    // R2
    run_count_chk: assert property (@(posedge clk) disable iff (rst)
        run_o |-> (st_q.cnt != '0));
endmodule

// File: rtl/cons_hold_group_stop.sv
module cons_hold_group_stop
    import cons_hold_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_CONS-1:0]       expire_i,
    input  logic [N_CONS*GRP_W-1:0] group_i,
    input  logic                    mask_we_i,
    input  logic [GRP_W-1:0]        mask_grp_i,
    input  logic [N_PROV-1:0]       mask_data_i,
    input  logic                    prov_we_i,
    input  logic [N_PROV-1:0]       prov_data_i,
    input  logic                    mbox_clr_i,
    output logic [N_PROV-1:0]       prov_o,
    output logic                    pending_o,
    output logic [7:0]              code_o
);
    logic [N_PROV-1:0] mask_q [N_GRP];
    logic [N_PROV-1:0] prov_q;
    logic [N_PROV-1:0] keep;
    logic [N_PROV-1:0] prov_base;
    evt_code_e         code_q;
    logic              pending_q;

    always_comb begin
        keep = '1;
        for (int c = 0; c < N_CONS; c++)
            if (expire_i[c])
                keep = keep & mask_q[group_i[c*GRP_W +: GRP_W]];
    end

    assign prov_base = prov_we_i ? prov_data_i : prov_q;

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_mask
            always_ff @(posedge clk) begin
                if (rst)
                    mask_q[g] <= '1;
                else if (mask_we_i && mask_grp_i == GRP_W'(g))
                    mask_q[g] <= mask_data_i;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prov_q    <= '0;
            pending_q <= 1'b0;
            code_q    <= EV_NONE;
        end else begin
            prov_q <= prov_base & keep;
            if (|expire_i) begin
                pending_q <= 1'b1;
                code_q    <= EV_HOLD_EXP;
            end else if (mbox_clr_i)
                pending_q <= 1'b0;
        end
    end

    assign prov_o    = prov_q;
    assign pending_o = pending_q;
    assign code_o    = code_q;

    // R8
    mbox_post_chk: assert property (@(posedge clk) disable iff (rst)
        (|expire_i) |=> (pending_o && code_o == 8'h01));
    // R10
    prov_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !prov_we_i |=> ((prov_o & ~$past(prov_o)) == '0));
endmodule

// File: rtl/cons_hold_watchdog.sv
module cons_hold_watchdog
    import cons_hold_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               base_tick,
    input  logic [SHIFT_W-1:0] scf_shift,
    input  logic               frame_valid,
    input  logic [IDX_W-1:0]   frame_idx,
    input  logic               act_we,
    input  logic [IDX_W-1:0]   act_idx,
    input  logic               act_on,
    input  logic [CNT_W-1:0]   act_reload,
    input  logic [GRP_W-1:0]   act_group,
    input  logic               mask_we,
    input  logic [GRP_W-1:0]   mask_grp,
    input  logic [N_PROV-1:0]  mask_data,
    input  logic               prov_we,
    input  logic [N_PROV-1:0]  prov_data,
    input  logic               mbox_clr,
    output logic [N_CONS-1:0]  cons_run,
    output logic [N_CONS-1:0]  cons_expired,
    output logic [N_PROV-1:0]  prov_active,
    output logic               evt_pending,
    output logic [7:0]         evt_code
);
    logic                    cycle;
    logic [N_CONS-1:0]       expire_vec;
    logic [N_CONS*GRP_W-1:0] grp_vec;

    cons_hold_prescaler u_pre (
        .clk(clk), .rst(rst), .base_tick_i(base_tick),
        .shift_i(scf_shift), .cycle_o(cycle)
    );

    generate
        for (genvar c = 0; c < N_CONS; c++) begin : g_chan
            cons_hold_channel u_chan (
                .clk(clk), .rst(rst), .cycle_i(cycle),
                .frame_i(frame_valid && frame_idx == IDX_W'(c)),
                .act_we_i(act_we && act_idx == IDX_W'(c)),
                .act_on_i(act_on), .reload_i(act_reload), .group_i(act_group),
                .run_o(cons_run[c]), .expired_o(cons_expired[c]),
                .expire_o(expire_vec[c]), .group_o(grp_vec[c*GRP_W +: GRP_W])
            );
        end
    endgenerate

    cons_hold_group_stop u_stop (
        .clk(clk), .rst(rst), .expire_i(expire_vec), .group_i(grp_vec),
        .mask_we_i(mask_we), .mask_grp_i(mask_grp), .mask_data_i(mask_data),
        .prov_we_i(prov_we), .prov_data_i(prov_data), .mbox_clr_i(mbox_clr),
        .prov_o(prov_active), .pending_o(evt_pending), .code_o(evt_code)
    );
endmodule

// File: tb/test_cons_hold_watchdog.sv
module test_cons_hold_watchdog;
    logic clk = 0, rst = 1;
    logic base_tick = 0, frame_valid = 0, act_we = 0, act_on = 0;
    logic mask_we = 0, prov_we = 0, mbox_clr = 0;
    logic [3:0] scf_shift = 0;
    logic [2:0] frame_idx = 0, act_idx = 0, act_group = 0, mask_grp = 0;
    logic [7:0] act_reload = 0, mask_data = 0, prov_data = 0;
    logic [7:0] cons_run, cons_expired, prov_active, evt_code;
    logic evt_pending;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // rows: {group, mask, provider field before, provider field expected}
    localparam logic [31:0] GK_VEC [0:4] = '{
        32'h00_F0_FF_F0, 32'h03_5A_0F_0A, 32'h07_FF_AA_AA,
        32'h05_00_3C_00, 32'h02_7E_81_00 };

    always #5 clk = ~clk;

    cons_hold_watchdog i_cons_hold_watchdog (.*);

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic activate(int i, int r, int g, bit on);
        @(negedge clk);
        act_we = 1; act_idx = 3'(i); act_reload = 8'(r); act_group = 3'(g); act_on = on;
        @(negedge clk);
        act_we = 0;
    endtask

    task automatic pulse();
        @(negedge clk); base_tick = 1;
        @(negedge clk); base_tick = 0;
    endtask

    task automatic frame(int i);
        @(negedge clk); frame_valid = 1; frame_idx = 3'(i);
        @(negedge clk); frame_valid = 0;
    endtask

    task automatic clr();
        @(negedge clk); mbox_clr = 1;
        @(negedge clk); mbox_clr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 run", cons_run, 0);
        check("R1 expired", cons_expired, 0);
        check("R1 prov", prov_active, 0);
        check("R1 pending", evt_pending, 0);
        check("R1 code", evt_code, 0);

        // R2 / R4: reload 3 fails on third send cycle
        activate(0, 3, 0, 1);
        check("R2 run after activate", cons_run[0], 1);
        pulse(); pulse();
        check("R4 still running", cons_run[0], 1);
        pulse();
        check("R4 run dropped", cons_run[0], 0);
        check("R4 expired set", cons_expired[0], 1);
        check("R8 pending", evt_pending, 1);
        check("R8 code", evt_code, 8'h01);

        // R3: shift 2 -> 4 base ticks per send cycle
        clr();
        scf_shift = 2;
        activate(1, 1, 0, 1);
        pulse(); pulse(); pulse();
        check("R3 before 4th tick", cons_run[1], 1);
        pulse();
        check("R3 after 4th tick", cons_run[1], 0);
        scf_shift = 0;

        // R5: frame reloads the counter
        activate(2, 2, 0, 1);
        pulse(); frame(2); pulse();
        check("R5 reloaded", cons_run[2], 1);
        pulse();
        check("R5 then expires", cons_expired[2], 1);
        // R5: frame coincident with send cycle wins
        activate(3, 1, 0, 1);
        @(negedge clk); base_tick = 1; frame_valid = 1; frame_idx = 3;
        @(negedge clk); base_tick = 0; frame_valid = 0;
        check("R5 coincident frame", cons_run[3], 1);
        // R11 deactivation
        activate(3, 1, 0, 0);
        check("R11 run off", cons_run[3], 0);
        check("R11 not expired", cons_expired[3], 0);

        // R6: idle consumer ignored
        clr();
        activate(4, 1, 0, 1);
        activate(4, 1, 0, 0);
        frame(4); pulse();
        check("R6 no event", evt_pending, 0);
        check("R6 not expired", cons_expired[4], 0);

        // R9: failed consumer stays failed
        frame(0); pulse();
        check("R9 still failed run", cons_run[0], 0);
        check("R9 still expired", cons_expired[0], 1);
        activate(0, 5, 0, 1);
        check("R9 reactivated run", cons_run[0], 1);
        check("R9 reactivated expired", cons_expired[0], 0);
        activate(0, 5, 0, 0);

        // R8: expiry beats clear in the same cycle
        activate(6, 1, 0, 1);
        @(negedge clk); base_tick = 1; mbox_clr = 1;
        @(negedge clk); base_tick = 0; mbox_clr = 0;
        check("R8 set wins", evt_pending, 1);
        clr();
        check("R8 cleared", evt_pending, 0);

        // R7 / R10: group stop vectors
        for (int k = 0; k < 5; k++) begin
            logic [31:0] v;
            v = GK_VEC[k];
            @(negedge clk); mask_we = 1; mask_grp = v[26:24]; mask_data = v[23:16];
            prov_we = 1; prov_data = v[15:8];
            @(negedge clk); mask_we = 0; prov_we = 0;
            activate(5, 1, int'(v[26:24]), 1);
            pulse();
            check($sformatf("R7 row %0d prov", k), prov_active, v[7:0]);
            check($sformatf("R7 row %0d event", k), evt_pending, 1);
            pulse();
            check($sformatf("R10 row %0d no rise", k), prov_active, v[7:0]);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule